// File: doc/BRIEF.md
# Programmable Identifier Acceptance Screen

This block decides whether a received frame should be kept, based on the frame's 32-bit identifier word. It holds four programmable filters. Each filter has a compare mask, a reference identifier and its own enable bit. The host programs the filters through a small register port. The receive path presents each identifier with a one-cycle valid strobe.

Two cycles after an identifier arrives, the block emits a one-cycle decision pulse. The pulse carries an accept flag and the index of the lowest-numbered enabled filter that matched. While a comparison is in flight, a busy status is raised. The mask and reference registers refuse writes while busy is high, and also while their own filter is enabled. This keeps the compare operands stable for any frame being judged. When no filter is enabled at all, every frame is accepted.

Register map (the address is `reg_waddr` or `reg_raddr`):

| Address | Write | Read |
|---|---|---|
| 0 | enable-set | enable bits |
| 1 | enable-clear | 0 |
| 2 | – | status (busy in bit 0) |
| 8 + 2k | mask of filter k | mask of filter k |
| 9 + 2k | reference ID of filter k | reference ID of filter k |

Top module: `id_screen_top`

## Requirements
- R1: After reset, all enable bits are 0, all masks and reference IDs are 0, `busy` is 0 and `dec_valid` is 0.
- R2: A write to address 0 sets the enable bits that are 1 in `reg_wdata[3:0]`. A write to address 1 clears those bits. All other enable bits are unchanged. A read of address 0 returns the enables in bits 3:0, and bits 31:4 always read 0.
- R3: While all four enable bits are 0, every identifier is accepted, with `dec_idx` = 0.
- R4: A write to filter k's mask (address 8+2k) or reference ID (address 9+2k) takes effect only if enable bit k is 0. Otherwise the register keeps its value.
- R5: `busy` and read bit 0 of address 2 are 1 in the cycle an identifier is strobed and in the following cycle. Mask and reference-ID writes made in those cycles are ignored.
- R6: Filter k matches when `((id_word ^ ref_k) & mask_k) == 0`. That is, only bit positions with a 1 in the mask are compared.
- R7: When at least one enable bit is set, `dec_accept` is 1 exactly when some enabled filter matches. Otherwise it is 0.
- R8: For an identifier strobed at clock edge T, `dec_valid` is high for exactly the one cycle that follows edge T+1.
- R9: `dec_idx` is the lowest-numbered enabled matching filter. It is 0 when the frame is rejected.
- R10: Identifiers strobed on consecutive cycles each produce their own decision, on consecutive cycles and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| id_valid | input | 1 | Identifier strobe |
| id_word | input | 32 | Received identifier word |
| busy | output | 1 | Comparison in flight; filter writes refused |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_idx | output | 2 | Lowest matching enabled filter |

## Verification
The following are checked on every cycle by assertions:
- the write guard on masks and reference IDs;
- the enable-set write never dropping a bit;
- the two-cycle decision latency;
- busy following a strobe;
- acceptance when no filter is enabled;
- the zero index on a rejection.

Only the bench's scenarios can show the rest:
- the actual mask-compare results;
- the lowest-index priority among several matching filters;
- the readback values;
- decisions for back-to-back identifiers.

// File: rtl/id_screen_pkg.sv
package id_screen_pkg;
    parameter int FLT_N  = 4;
    parameter int WORD_W = 32;
    parameter int ADDR_W = 4;
    localparam int IDX_W = $clog2(FLT_N);

    localparam int A_EN_SET   = 0;
    localparam int A_EN_CLR   = 1;
    localparam int A_STATUS   = 2;
    localparam int A_FLT_BASE = 8;

    typedef struct packed {
        logic             valid;
        logic             accept;
        logic [IDX_W-1:0] idx;
    } decision_t;

    // lowest set bit index of a candidate vector, 0 when none
    function automatic logic [IDX_W-1:0] first_hit(input logic [FLT_N-1:0] cand);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = FLT_N - 1; k >= 0; k--) begin
            if (cand[k]) r = IDX_W'(k);
        end
        return r;
    endfunction
endpackage

// File: rtl/id_screen_regs.sv
module id_screen_regs
    import id_screen_pkg::*;
#(
    parameter int NF = FLT_N,
    parameter int DW = WORD_W,
    parameter int AW = ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [AW-1:0]          rd_addr,
    input  logic                   busy,
    output logic [DW-1:0]          rd_data,
    output logic [NF-1:0]          en_q,
    output logic [NF-1:0][DW-1:0]  mask_q,
    output logic [NF-1:0][DW-1:0]  ref_q
);
    localparam logic [AW-1:0] ADDR_SET  = AW'(A_EN_SET);
    localparam logic [AW-1:0] ADDR_CLR  = AW'(A_EN_CLR);
    localparam logic [AW-1:0] ADDR_STAT = AW'(A_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en && wr_addr == ADDR_SET) begin
            en_q <= en_q | wr_data[NF-1:0];
        end else if (wr_en && wr_addr == ADDR_CLR) begin
            en_q <= en_q & ~wr_data[NF-1:0];
        end
    end

    p_en_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_SET) |=> ((en_q & $past(en_q)) == $past(en_q)));

    generate
        for (genvar k = 0; k < NF; k++) begin : g_flt
            localparam logic [AW-1:0] ADDR_M = AW'(A_FLT_BASE + 2 * k);
            localparam logic [AW-1:0] ADDR_R = AW'(A_FLT_BASE + 2 * k + 1);
            logic open_k;
            assign open_k = wr_en && !busy && !en_q[k];

            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q[k] <= '0;
                    ref_q[k]  <= '0;
                end else begin
                    if (open_k && wr_addr == ADDR_M) mask_q[k] <= wr_data;
                    if (open_k && wr_addr == ADDR_R) ref_q[k]  <= wr_data;
                end
            end

            p_mask_guard_r4: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == ADDR_M && (en_q[k] || busy)) |=> $stable(mask_q[k]));
            p_ref_guard_r5: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == ADDR_R && (en_q[k] || busy)) |=> $stable(ref_q[k]));
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_SET) rd_data[NF-1:0] = en_q;
        if (rd_addr == ADDR_STAT) rd_data[0] = busy;
        for (int k = 0; k < NF; k++) begin
            if (rd_addr == AW'(A_FLT_BASE + 2 * k))     rd_data = mask_q[k];
            if (rd_addr == AW'(A_FLT_BASE + 2 * k + 1)) rd_data = ref_q[k];
        end
    end
endmodule

// File: rtl/id_screen_match.sv
module id_screen_match
    import id_screen_pkg::*;
#(
    parameter int NF = FLT_N,
    parameter int DW = WORD_W
) (
    input  logic [DW-1:0]          rx_id,
    input  logic [NF-1:0][DW-1:0]  mask_q,
    input  logic [NF-1:0][DW-1:0]  ref_q,
    output logic [NF-1:0]          hit
);
    generate
        for (genvar k = 0; k < NF; k++) begin : g_cmp
            assign hit[k] = ~|((rx_id ^ ref_q[k]) & mask_q[k]);
        end
    endgenerate
endmodule

// File: rtl/id_screen_pick.sv
module id_screen_pick
    import id_screen_pkg::*;
#(
    parameter int NF = FLT_N
) (
    input  logic [NF-1:0]    hit,
    input  logic [NF-1:0]    en,
    output logic             accept,
    output logic [IDX_W-1:0] idx
);
    logic [NF-1:0] cand;
    assign cand   = hit & en;
    assign accept = (en == '0) || (cand != '0);
    assign idx    = first_hit(cand);
endmodule

// File: rtl/id_screen_top.sv
module id_screen_top
    import id_screen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_waddr,
    input  logic [WORD_W-1:0]     reg_wdata,
    input  logic [ADDR_W-1:0]     reg_raddr,
    output logic [WORD_W-1:0]     reg_rdata,
    input  logic                  id_valid,
    input  logic [WORD_W-1:0]     id_word,
    output logic                  busy,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic [IDX_W-1:0]      dec_idx
);
    logic [FLT_N-1:0]             en_q;
    logic [FLT_N-1:0][WORD_W-1:0] mask_q;
    logic [FLT_N-1:0][WORD_W-1:0] ref_q;
    logic [FLT_N-1:0]             hit;
    logic                         pick_acc;
    logic [IDX_W-1:0]             pick_idx;

    logic              s1_v;
    logic [WORD_W-1:0] s1_id;
    decision_t         dec_q;

    assign busy = id_valid | s1_v;

    id_screen_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_waddr),
        .wr_data(reg_wdata), .rd_addr(reg_raddr), .busy(busy),
        .rd_data(reg_rdata), .en_q(en_q), .mask_q(mask_q), .ref_q(ref_q)
    );

    id_screen_match u_match (
        .rx_id(s1_id), .mask_q(mask_q), .ref_q(ref_q), .hit(hit)
    );

    id_screen_pick u_pick (
        .hit(hit), .en(en_q), .accept(pick_acc), .idx(pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v  <= 1'b0;
            s1_id <= '0;
            dec_q <= '0;
        end else begin
            s1_v  <= id_valid;
            if (id_valid) s1_id <= id_word;
            dec_q.valid  <= s1_v;
            dec_q.accept <= s1_v & pick_acc;
            dec_q.idx    <= s1_v ? pick_idx : '0;
        end
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
    assign dec_idx    = dec_q.idx;

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> ##2 dec_valid);
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> busy);
    p_open_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(en_q) == '0) |-> (dec_accept && dec_idx == '0));
    p_reject_idx_r9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |-> (dec_idx == '0));
    p_no_stray_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(busy) && !busy) |-> !dec_valid);
endmodule

// File: tb/tb_id_screen_top.sv
module tb_id_screen_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        id_valid = 1'b0;
    logic [31:0] id_word = '0;
    logic        busy, dec_valid, dec_accept;
    logic [1:0]  dec_idx;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    id_screen_top dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .id_valid(id_valid), .id_word(id_word), .busy(busy),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_idx(dec_idx)
    );

    typedef struct packed {
        logic [3:0]  en;
        logic [31:0] id;
        logic        acc;
        logic [1:0]  idx;
    } vec_t;

    // filters: 0 upper half 1234, 1 low byte 55, 2 exact DEADBEEF, 3 match-all
    localparam vec_t VEC [9] = '{
        '{4'b0111, 32'h1234_0055, 1'b1, 2'd0},
        '{4'b0111, 32'h9999_0055, 1'b1, 2'd1},
        '{4'b0111, 32'hDEAD_BEEF, 1'b1, 2'd2},
        '{4'b0111, 32'h0000_0000, 1'b0, 2'd0},
        '{4'b1111, 32'h0000_0000, 1'b1, 2'd3},
        '{4'b1010, 32'h1234_0055, 1'b1, 2'd1},
        '{4'b0000, 32'hCAFE_F00D, 1'b1, 2'd0},
        '{4'b0100, 32'h1234_0055, 1'b0, 2'd0},
        '{4'b1000, 32'hCAFE_F00D, 1'b1, 2'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic judge(input logic [31:0] id, input logic acc, input logic [1:0] idx, input string tag);
        @(negedge clk);
        id_valid = 1'b1; id_word = id;
        #1 chk({tag, " busy in strobe cycle R5"}, 32'(busy), 32'd1);
        @(negedge clk);
        id_valid = 1'b0;
        chk({tag, " no early pulse R8"}, 32'(dec_valid), 32'd0);
        @(negedge clk);
        chk({tag, " pulse R8"}, 32'(dec_valid), 32'd1);
        chk({tag, " accept R7"}, 32'(dec_accept), 32'(acc));
        chk({tag, " index R9"}, 32'(dec_idx), 32'(idx));
        @(negedge clk);
        chk({tag, " single pulse R8"}, 32'(dec_valid), 32'd0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, v);  chk("reset enables R1", v, 32'd0);
        rd(4'd8, v);  chk("reset mask0 R1", v, 32'd0);
        rd(4'd15, v); chk("reset ref3 R1", v, 32'd0);
        chk("reset busy R1", 32'(busy), 32'd0);
        chk("reset pulse R1", 32'(dec_valid), 32'd0);

        // R2 set/clear enable bits
        wr(4'd0, 32'h5); wr(4'd0, 32'h2);
        rd(4'd0, v); chk("enable set merges R2", v, 32'h7);
        wr(4'd1, 32'h4);
        rd(4'd0, v); chk("enable clear selected R2", v, 32'h3);
        wr(4'd0, 32'hFFFF_FFF0);
        rd(4'd0, v); chk("upper bits read zero R2", v, 32'h3);
        wr(4'd1, 32'hF);

        // program filters (all disabled)
        wr(4'd8,  32'hFFFF_0000); wr(4'd9,  32'h1234_0000);
        wr(4'd10, 32'h0000_00FF); wr(4'd11, 32'h0000_0055);
        wr(4'd12, 32'hFFFF_FFFF); wr(4'd13, 32'hDEAD_BEEF);
        wr(4'd14, 32'h0000_0000); wr(4'd15, 32'h0000_0000);
        rd(4'd13, v); chk("ref2 readback R4", v, 32'hDEAD_BEEF);

        // R4 guarded write while enabled
        wr(4'd0, 32'h1);
        wr(4'd8, 32'h0000_AAAA);
        rd(4'd8, v); chk("mask0 locked while enabled R4", v, 32'hFFFF_0000);
        wr(4'd9, 32'h1111_1111);
        rd(4'd9, v); chk("ref0 locked while enabled R4", v, 32'h1234_0000);
        wr(4'd1, 32'hF);

        // table: R3 R6 R7 R9
        foreach (VEC[i]) begin
            wr(4'd1, 32'hF);
            wr(4'd0, {28'd0, VEC[i].en});
            judge(VEC[i].id, VEC[i].acc, VEC[i].idx, $sformatf("vec%0d R6", i));
        end

        // R3 explicit: nothing enabled, an arbitrary word is accepted
        wr(4'd1, 32'hF);
        judge(32'h0BAD_0BAD, 1'b1, 2'd0, "all disabled R3");

        // R5 writes during busy are ignored (filter 1 disabled)
        @(negedge clk);
        id_valid = 1'b1; id_word = 32'h0;
        reg_wr = 1'b1; reg_waddr = 4'd10; reg_wdata = 32'h1;
        @(negedge clk);
        id_valid = 1'b0;
        reg_waddr = 4'd11; reg_wdata = 32'h2;
        rd(4'd2, v); chk("status busy bit R5", v, 32'd1);
        @(negedge clk);
        reg_wr = 1'b0;
        rd(4'd10, v); chk("mask1 write in strobe cycle ignored R5", v, 32'h0000_00FF);
        rd(4'd11, v); chk("ref1 write in busy cycle ignored R5", v, 32'h0000_0055);
        rd(4'd2, v); chk("status idle R5", v, 32'd0);

        // R10 back-to-back identifiers, filters 0..2 enabled
        wr(4'd0, 32'h7);
        @(negedge clk);
        id_valid = 1'b1; id_word = 32'h9999_0055;
        @(negedge clk);
        id_word = 32'hDEAD_BEEF;
        @(negedge clk);
        id_valid = 1'b0;
        chk("b2b first pulse R10", 32'(dec_valid), 32'd1);
        chk("b2b first idx R10", 32'(dec_idx), 32'd1);
        chk("b2b busy held R10", 32'(busy), 32'd1);
        @(negedge clk);
        chk("b2b second pulse R10", 32'(dec_valid), 32'd1);
        chk("b2b second idx R10", 32'(dec_idx), 32'd2);
        @(negedge clk);
        chk("b2b end R10", 32'(dec_valid), 32'd0);

        summary();
    end
endmodule